// File: doc/BRIEF.md
# Vertical Retrace Sequencer

This block generates the vertical blanking interval of a 640x480 display, one frame at a time, on request from software. The processor paints the 480 visible lines itself, then writes to a start register. From that write on, the block counts horizontal line ticks through a 45-line retrace window. It drives the vertical sync pulse at a fixed place inside that window, and then returns to idle. No hardware counts the visible lines.

The line count and a busy flag are always readable on a single read data port. Code running in the retrace window can therefore see how many line periods it has left and budget its work. At a line rate near 31.5 kHz the window lasts about 1.5 ms of the roughly 16.6 ms frame.

Top module: `vrt_retrace_gen`

## Requirements
- R1: After reset the block is idle: read data is all zeros (count 0, busy flag 0) and the sync output is at its inactive level (high, with the default active-low polarity).
- R2: A start strobe seen while idle makes the block busy from the next cycle, with the count at 0.
- R3: While busy, each cycle with a line tick raises the count by exactly one. A cycle without a tick leaves the count unchanged.
- R4: A line tick arriving while busy with the count at 44 ends the sequence: from the next cycle the count is 0 and the busy flag is 0.
- R5: The sync output is active (low) exactly while busy with the count at 10 or 11, and inactive in every other state.
- R6: A start strobe seen while busy has no effect: the count and the busy flag evolve as if the strobe were absent, so the sequence ends at the same tick.
- R7: Line ticks seen while idle have no effect: the count stays 0, the busy flag stays 0 and sync stays inactive.
- R8: Read data layout: bits [5:0] carry the count, bit 7 carries the busy flag and bit 6 reads 0.
- R9: Once a sequence has ended, a new start strobe starts a fresh 45-line sequence. This includes a strobe that coincides with a line tick, which starts the sequence at count 0 without advancing it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_tick_i | input | 1 | One-cycle pulse per horizontal line |
| start_wr_i | input | 1 | One-cycle software write strobe that starts retrace |
| rd_data_o | output | 8 | Readable register: count in [5:0], busy flag in bit 7 |
| vsync_o | output | 1 | Vertical sync, active low by default |

## Verification
The bench builds the block with its defaults: 45 retrace lines, 10 lines before sync, a 2-line pulse, active-low polarity and an 8-bit read port. These values put the sync window edges at counts 9/10 and 11/12 and the wrap at 44 within one short sequence. Two complete sequences run back to back. The first is interleaved with start strobes while busy and with tick-free gaps inside the sync window. The second is started by a strobe that lands together with a tick. Every cycle's read data and sync level are compared against a reference model of the requirements.

// File: rtl/vrt_pkg.sv
package vrt_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vrt_state_e;

endpackage

// File: rtl/vrt_ctrl.sv
module vrt_ctrl
  import vrt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  input  logic last_i,
  output logic run_o,
  output logic adv_o
);

  vrt_state_e state_q, state_d;

  // next-state process
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN:  if (tick_i && last_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign run_o = (state_q == ST_RUN);
  // counter only moves on a tick while the sequence runs
  assign adv_o = run_o && tick_i;

endmodule

// File: rtl/vrt_line_cnt.sv
module vrt_line_cnt #(
  parameter int unsigned LINES = 45,
  localparam int unsigned CNT_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(LINES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign last_o = (cnt_q == LAST_VAL);
  assign cnt_en = adv_i;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      if (last_o) cnt_d = '0;
      else        cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/vrt_sync_dec.sv
module vrt_sync_dec #(
  parameter int unsigned CNT_W       = 6,
  parameter int unsigned FRONT_LINES = 10,
  parameter int unsigned SYNC_LINES  = 2,
  parameter bit          ACTIVE_LOW  = 1'b1
) (
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             sync_o
);

  localparam int unsigned SYNC_END = FRONT_LINES + SYNC_LINES;

  logic in_win;

  assign in_win = run_i
               && (cnt_i >= CNT_W'(FRONT_LINES))
               && (cnt_i <  CNT_W'(SYNC_END));

  generate
    if (ACTIVE_LOW) begin : g_low
      assign sync_o = ~in_win;
    end else begin : g_high
      assign sync_o = in_win;
    end
  endgenerate

endmodule

// File: rtl/vrt_retrace_gen.sv
module vrt_retrace_gen #(
  parameter int unsigned LINES           = 45,
  parameter int unsigned FRONT_LINES     = 10,
  parameter int unsigned SYNC_LINES      = 2,
  parameter bit          SYNC_ACTIVE_LOW = 1'b1,
  parameter int unsigned DATA_W          = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_tick_i,
  input  logic              start_wr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              vsync_o
);

  localparam int unsigned CNT_W = $clog2(LINES);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic             run, adv, last;
  logic [CNT_W-1:0] cnt;

  vrt_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .start_i (start_wr_i),
    .tick_i  (line_tick_i),
    .last_i  (last),
    .run_o   (run),
    .adv_o   (adv)
  );

  vrt_line_cnt #(.LINES(LINES)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .adv_i  (adv),
    .cnt_o  (cnt),
    .last_o (last)
  );

  vrt_sync_dec #(
    .CNT_W       (CNT_W),
    .FRONT_LINES (FRONT_LINES),
    .SYNC_LINES  (SYNC_LINES),
    .ACTIVE_LOW  (SYNC_ACTIVE_LOW)
  ) u_sync (
    .run_i  (run),
    .cnt_i  (cnt),
    .sync_o (vsync_o)
  );

  always_comb begin
    rd_data_o             = '0;
    rd_data_o[CNT_W-1:0]  = cnt;
    rd_data_o[DATA_W-1]   = run;
  end

endmodule

// File: rtl/vrt_retrace_gen_chk.sv
module vrt_retrace_gen_chk #(
  parameter int unsigned LINES           = 45,
  parameter int unsigned FRONT_LINES     = 10,
  parameter int unsigned SYNC_LINES      = 2,
  parameter bit          SYNC_ACTIVE_LOW = 1'b1,
  parameter int unsigned DATA_W          = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line_tick_i,
  input logic              start_wr_i,
  input logic [DATA_W-1:0] rd_data_i,
  input logic              vsync_i
);

  localparam int unsigned CNT_W = $clog2(LINES);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(LINES - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             sync_on;

  assign busy    = rd_data_i[DATA_W-1];
  assign cnt     = rd_data_i[CNT_W-1:0];
  assign sync_on = SYNC_ACTIVE_LOW ? !vsync_i : vsync_i;

  assert_idle_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (cnt == '0) && !sync_on);

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && start_wr_i) |=> busy && (cnt == '0));

  assert_advance_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && line_tick_i && (cnt != LAST_VAL)) |=> busy && (cnt == $past(cnt) + CNT_W'(1)));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !line_tick_i) |=> busy && $stable(cnt));

  assert_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && line_tick_i && (cnt == LAST_VAL)) |=> !busy && (cnt == '0));

  assert_sync_in_win_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && (cnt >= CNT_W'(FRONT_LINES)) && (cnt < CNT_W'(FRONT_LINES + SYNC_LINES))) |-> sync_on);

  assert_sync_only_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_on |-> busy);

  assert_idle_stays_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_wr_i) |=> !busy);

  assert_pad_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_i[DATA_W-2:CNT_W] == '0);

endmodule

bind vrt_retrace_gen vrt_retrace_gen_chk #(
  .LINES           (LINES),
  .FRONT_LINES     (FRONT_LINES),
  .SYNC_LINES      (SYNC_LINES),
  .SYNC_ACTIVE_LOW (SYNC_ACTIVE_LOW),
  .DATA_W          (DATA_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_n_int),
  .line_tick_i (line_tick_i),
  .start_wr_i  (start_wr_i),
  .rd_data_i   (rd_data_o),
  .vsync_i     (vsync_o)
);

// File: tb/vrt_retrace_gen_tb.sv
`timescale 1ns/1ps
module vrt_retrace_gen_tb_top;

  localparam int LINES = 45;
  localparam int FRONT = 10;
  localparam int SYNCL = 2;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       start;
  logic [7:0] rd_data;
  logic       vsync;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference model state
  bit m_busy = 0;
  int m_cnt  = 0;

  logic [8:0] q_val[$];
  string      q_tag[$];

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  vrt_retrace_gen dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .line_tick_i (tick),
    .start_wr_i  (start),
    .rd_data_o   (rd_data),
    .vsync_o     (vsync)
  );

  function automatic logic [8:0] model_out();
    logic [7:0] rd;
    logic       vs;
    rd      = 8'h00;
    rd[5:0] = 6'(m_cnt);
    rd[7]   = m_busy;
    vs      = !(m_busy && m_cnt >= FRONT && m_cnt < FRONT + SYNCL);
    return {rd, vs};
  endfunction

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(input logic s, input logic t, input string tag);
    @(negedge clk);
    start = s;
    tick  = t;
    if (!m_busy) begin
      if (s) begin m_busy = 1; m_cnt = 0; end
    end else if (t) begin
      if (m_cnt == LINES - 1) begin m_busy = 0; m_cnt = 0; end
      else m_cnt = m_cnt + 1;
    end
    q_val.push_back(model_out());
    q_tag.push_back(tag);
  endtask

  // monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_val.size() > 0) begin
        logic [8:0] e;
        string      tg;
        e  = q_val.pop_front();
        tg = q_tag.pop_front();
        n_vec++;
        if ({rd_data, vsync} !== e) begin
          n_fail++;
          $display("FAIL %s: rd_data=%h vsync=%b expected rd_data=%h vsync=%b",
                   tg, rd_data, vsync, e[8:1], e[0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    tick  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (rd_data !== 8'h00 || vsync !== 1'b1) begin  // R1
      n_fail++;
      $display("FAIL R1: rd_data=%h vsync=%b expected rd_data=00 vsync=1", rd_data, vsync);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: ticks while idle
    repeat (3) step(1'b0, 1'b1, "R7");
    step(1'b0, 1'b0, "R7");

    // R2: start, then R3 hold without ticks
    step(1'b1, 1'b0, "R2");
    step(1'b0, 1'b0, "R3");
    step(1'b0, 1'b0, "R8");

    // first sequence with stray starts and gaps
    for (int k = 1; k <= LINES; k++) begin
      string tg;
      if (k == LINES)            tg = "R4";
      else if (k >= 9 && k <= 12) tg = "R5";
      else                        tg = "R3";
      step(1'b0, 1'b1, tg);
      if (k == 10 || k == 11) step(1'b0, 1'b0, "R5");
      if (k == 20) begin
        step(1'b1, 1'b0, "R6");
        step(1'b1, 1'b1, "R6");
      end
      if (k == 43) step(1'b1, 1'b0, "R6");
    end

    // idle again, ticks ignored
    step(1'b0, 1'b1, "R7");
    step(1'b0, 1'b0, "R4");

    // R9: restart with start and tick together
    step(1'b1, 1'b1, "R9");
    for (int k = 1; k <= LINES; k++) begin
      string tg;
      tg = (k == 10 || k == 12) ? "R5" : "R9";
      step(1'b0, 1'b1, tg);
    end
    step(1'b0, 1'b0, "R9");

    @(negedge clk);
    start = 1'b0;
    tick  = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule